// File: doc/BRIEF.md
# Select-Coded Arithmetic-Logic Unit with Status Flags

This block is a combinational N-bit arithmetic-logic unit. It takes two operands, a 3-bit function select and a carry input. It returns a result word and four status flags: carry, sign, zero and overflow. Every arithmetic function comes from one ripple-carry adder. The two low select bits choose what is fed into the adder's second input: zero, the B operand, the inverted B operand or all ones. The carry input is added at the least significant stage. These two controls together give eight arithmetic functions, including transfer, increment, add, subtract and decrement.

The same two low select bits choose one of four bitwise logic operations. The top select bit decides whether the arithmetic result or the logic result drives the output. The four flags are also available as a registered copy, which is updated on every clock edge. This lets a surrounding pipeline use the status of the previous operation.

Top module: `aluSelUnit`

## Requirements
- R1: `sel[2]`=0 puts the arithmetic result on `result`, and `sel[2]`=1 puts the logic result on `result`.
- R2: In arithmetic mode, `result` = (`opA` + X + `carryIn`) mod 2^WIDTH. X is 0 for `sel[1:0]`=00, `opB` for 01, ~`opB` for 10 and all ones for 11. So 10 with `carryIn`=1 gives `opA`-`opB`, and 11 with `carryIn`=0 gives `opA`-1.
- R3: In logic mode, `sel[1:0]`=00 gives `opA` AND `opB`, 01 gives OR, 10 gives XOR and 11 gives NOT `opA`. `carryIn` has no effect on any output in this mode.
- R4: `flagCarry` is the carry out of the top adder stage in arithmetic mode and is 0 in logic mode.
- R5: `flagSign` equals `result[WIDTH-1]`, and `flagZero` is 1 exactly when every bit of `result` is 0. Both rules hold in both modes.
- R6: `flagOvf` is the XOR of the carry into the top stage and the carry out of it in arithmetic mode. It equals two's-complement overflow of `opA`+X+`carryIn`. It is 0 in logic mode.
- R7: `flagsQ` = {carry, sign, zero, overflow} (bit 3 down to bit 0) holds the flags present before the last rising clock edge. While `rstN` is low it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered flags |
| rstN | input | 1 | Active-low synchronous reset of the registered flags |
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand |
| sel | input | 3 | Function select: bit 2 chooses the path, bits 1:0 choose the function |
| carryIn | input | 1 | Carry into the least significant adder stage |
| result | output | WIDTH | Selected result |
| flagCarry | output | 1 | Carry out of the top stage |
| flagSign | output | 1 | Most significant bit of the result |
| flagZero | output | 1 | Result is all zero |
| flagOvf | output | 1 | Signed overflow |
| flagsQ | output | 4 | Registered {carry, sign, zero, overflow} |

## Verification
The combinational outputs have no state. A broken carry chain, a misrouted second adder input or a wrong decode therefore shows on `result` or on the flags in the same cycle, for the matching select and carry-in combination. A wrong value held in the flag register shows on `flagsQ` one edge after the operation that produced it. The bench walks every select, carry-in and operand pair, so each such fault reaches the ports within one pass.

// File: rtl/aluSelPkg.sv
package aluSelPkg;
  typedef enum logic [1:0] {
    B_ZERO  = 2'b00,
    B_PLAIN = 2'b01,
    B_INV   = 2'b10,
    B_ONES  = 2'b11
  } bSrcE;

  typedef enum logic [1:0] {
    L_AND  = 2'b00,
    L_OR   = 2'b01,
    L_XOR  = 2'b10,
    L_NOTA = 2'b11
  } logOpE;

  typedef struct packed {
    logic  useLogic;
    bSrcE  bSrc;
    logOpE logOp;
    logic  carryEn;
  } aluCtrlT;

  localparam int FLAG_BITS = 4;
endpackage

// File: rtl/aluFullAdder.sv
module aluFullAdder (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  assign s  = a ^ b ^ ci;
  assign co = (a & b) | (ci & (a ^ b));
endmodule

// File: rtl/aluSelCtrl.sv
module aluSelCtrl
  import aluSelPkg::*;
(
  input  logic [2:0] sel,
  output aluCtrlT    ctrl
);
  always_comb begin
    ctrl.useLogic = sel[2];
    ctrl.bSrc     = bSrcE'(sel[1:0]);
    ctrl.logOp    = logOpE'(sel[1:0]);
    ctrl.carryEn  = ~sel[2];
  end
endmodule

// File: rtl/aluSelDatapath.sv
module aluSelDatapath
  import aluSelPkg::*;
#(
  parameter int WIDTH = 4
) (
  input  aluCtrlT           ctrl,
  input  logic [WIDTH-1:0]  opA,
  input  logic [WIDTH-1:0]  opB,
  input  logic              carryIn,
  output logic [WIDTH-1:0]  result,
  output logic              flagCarry,
  output logic              flagSign,
  output logic              flagZero,
  output logic              flagOvf
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] bSide;
  logic [WIDTH-1:0] sumBits;
  logic [WIDTH-1:0] logicBits;
  logic [WIDTH:0]   chain;

  always_comb begin
    unique case (ctrl.bSrc)
      B_ZERO:  bSide = '0;
      B_PLAIN: bSide = opB;
      B_INV:   bSide = ~opB;
      default: bSide = '1;
    endcase
  end

  assign chain[0] = carryIn & ctrl.carryEn;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    aluFullAdder fa_i (
      .a  (opA[i]),
      .b  (bSide[i]),
      .ci (chain[i]),
      .s  (sumBits[i]),
      .co (chain[i+1])
    );
  end

  always_comb begin
    unique case (ctrl.logOp)
      L_AND:   logicBits = opA & opB;
      L_OR:    logicBits = opA | opB;
      L_XOR:   logicBits = opA ^ opB;
      default: logicBits = ~opA;
    endcase
  end

  assign result    = ctrl.useLogic ? logicBits : sumBits;
  assign flagCarry = ~ctrl.useLogic & chain[WIDTH];
  assign flagOvf   = ~ctrl.useLogic & (chain[WIDTH] ^ chain[MSB]);
  assign flagSign  = result[MSB];
  assign flagZero  = ~|result;
endmodule

// File: rtl/aluSelUnit.sv
module aluSelUnit
  import aluSelPkg::*;
#(
  parameter int WIDTH     = 4,
  parameter bit REG_FLAGS = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [WIDTH-1:0]     opA,
  input  logic [WIDTH-1:0]     opB,
  input  logic [2:0]           sel,
  input  logic                 carryIn,
  output logic [WIDTH-1:0]     result,
  output logic                 flagCarry,
  output logic                 flagSign,
  output logic                 flagZero,
  output logic                 flagOvf,
  output logic [FLAG_BITS-1:0] flagsQ
);
  aluCtrlT ctrl;

  aluSelCtrl ctrl_i (
    .sel  (sel),
    .ctrl (ctrl)
  );

  aluSelDatapath #(.WIDTH(WIDTH)) dp_i (
    .ctrl      (ctrl),
    .opA       (opA),
    .opB       (opB),
    .carryIn   (carryIn),
    .result    (result),
    .flagCarry (flagCarry),
    .flagSign  (flagSign),
    .flagZero  (flagZero),
    .flagOvf   (flagOvf)
  );

  logic [FLAG_BITS-1:0] flagsNow;
  assign flagsNow = {flagCarry, flagSign, flagZero, flagOvf};

  if (REG_FLAGS) begin : g_regFlags
    always_ff @(posedge clk) begin
      if (!rstN) flagsQ <= '0;
      else       flagsQ <= flagsNow;
    end
  end else begin : g_passFlags
    assign flagsQ = flagsNow;
  end
endmodule

// File: rtl/aluSelUnit_chk.sv
module aluSelUnit_chk #(
  parameter int WIDTH     = 4,
  parameter bit REG_FLAGS = 1'b1
) (
  input logic             clk,
  input logic             rstN,
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [2:0]       sel,
  input logic             carryIn,
  input logic [WIDTH-1:0] result,
  input logic             flagCarry,
  input logic             flagSign,
  input logic             flagZero,
  input logic             flagOvf,
  input logic [3:0]       flagsQ
);
  p_logic_no_carry_r4: assert property (@(posedge clk) disable iff (!rstN)
    sel[2] |-> !flagCarry);

  p_logic_no_ovf_r6: assert property (@(posedge clk) disable iff (!rstN)
    sel[2] |-> !flagOvf);

  p_add_ovf_r6: assert property (@(posedge clk) disable iff (!rstN)
    (sel == 3'b001 && !carryIn) |->
      (flagOvf == ((opA[WIDTH-1] == opB[WIDTH-1]) && (result[WIDTH-1] != opA[WIDTH-1]))));

  p_transfer_a_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((sel == 3'b000 && !carryIn) || (sel == 3'b011 && carryIn)) |-> result == opA);

  p_zero_flag_r5: assert property (@(posedge clk) disable iff (!rstN)
    flagZero == (result == '0));

  p_and_path_r1: assert property (@(posedge clk) disable iff (!rstN)
    (sel == 3'b100) |-> result == (opA & opB));

  p_cin_ignored_r3: assert property (@(posedge clk) disable iff (!rstN)
    (sel[2] && $past(sel[2]) && $stable(opA) && $stable(opB) && $stable(sel))
      |-> $stable(result) && $stable(flagZero));

  if (REG_FLAGS) begin : g_regChk
    p_flag_reg_r7: assert property (@(posedge clk) disable iff (!rstN)
      $past(rstN) |-> flagsQ == $past({flagCarry, flagSign, flagZero, flagOvf}));
  end
endmodule

bind aluSelUnit aluSelUnit_chk #(.WIDTH(WIDTH), .REG_FLAGS(REG_FLAGS)) chk_i (
  .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .sel(sel), .carryIn(carryIn),
  .result(result), .flagCarry(flagCarry), .flagSign(flagSign),
  .flagZero(flagZero), .flagOvf(flagOvf), .flagsQ(flagsQ)
);

// File: tb/aluSelUnit_tb_top.sv
`timescale 1ns/1ps
module aluSelUnit_tb_top;
  localparam int W   = 4;
  localparam int MOD = 1 << W;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] opA = '0, opB = '0;
  logic [2:0]   sel = '0;
  logic         carryIn = 1'b0;
  logic [W-1:0] result;
  logic         flagCarry, flagSign, flagZero, flagOvf;
  logic [3:0]   flagsQ;

  int total = 0;
  int bad = 0;
  logic [3:0] expFlagsQ = '0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  aluSelUnit #(.WIDTH(W), .REG_FLAGS(1'b1)) dut_i (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .sel(sel), .carryIn(carryIn),
    .result(result), .flagCarry(flagCarry), .flagSign(flagSign),
    .flagZero(flagZero), .flagOvf(flagOvf), .flagsQ(flagsQ)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (sel=%0d cin=%0d a=%0d b=%0d)",
               req, act, exp, sel, carryIn, opA, opB);
    end
  endtask

  task automatic runVector(input int s, input int c, input int a, input int b);
    int bs, sum, sa, sb, ss, eF, eC, eV, eS, eZ;
    @(negedge clk);
    sel = 3'(s); carryIn = c[0]; opA = W'(a); opB = W'(b);
    if (s < 4) begin
      case (s)
        0: bs = 0;
        1: bs = b;
        2: bs = (MOD - 1) - b;
        default: bs = MOD - 1;
      endcase
      sum = a + bs + c;
      eF  = sum % MOD;
      eC  = sum / MOD;
      sa  = (a  >= MOD/2) ? a  - MOD : a;
      sb  = (bs >= MOD/2) ? bs - MOD : bs;
      ss  = sa + sb + c;
      eV  = (ss >= MOD/2 || ss < -(MOD/2)) ? 1 : 0;
    end else begin
      case (s)
        4: eF = a & b;
        5: eF = a | b;
        6: eF = a ^ b;
        default: eF = (MOD - 1) - a;
      endcase
      eC = 0;
      eV = 0;
    end
    eS = (eF >= MOD/2) ? 1 : 0;
    eZ = (eF == 0) ? 1 : 0;
    #1;
    check(s < 4 ? "R2 arith result" : "R3 logic result", int'(result), eF);
    check("R1 path select", int'(result), eF);
    check("R4 carry", int'(flagCarry), eC);
    check("R5 sign", int'(flagSign), eS);
    check("R5 zero", int'(flagZero), eZ);
    check("R6 overflow", int'(flagOvf), eV);
    expFlagsQ = {eC[0], eS[0], eZ[0], eV[0]};
    @(posedge clk); #1;
    check("R7 registered flags", int'(flagsQ), int'(expFlagsQ));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    #1;
    check("R7 reset value", int'(flagsQ), 0);
    @(negedge clk); rstN = 1'b1;
    for (int s = 0; s < 8; s++)
      for (int c = 0; c < 2; c++)
        for (int a = 0; a < MOD; a++)
          for (int b = 0; b < MOD; b++)
            runVector(s, c, a, b);
    // R3: carry-in toggling with a logic op leaves the outputs unchanged
    runVector(6, 0, 9, 5);
    @(negedge clk); carryIn = 1'b1; #1;
    check("R3 cin ignored result", int'(result), 12);
    check("R3 cin ignored carry", int'(flagCarry), 0);
    // R7: reset clears the flag register after a nonzero value
    runVector(1, 0, 15, 1);
    @(negedge clk); rstN = 1'b0;
    @(posedge clk); #1;
    check("R7 reset clears", int'(flagsQ), 0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule